// File: doc/BRIEF.md
# Instruction Decode Stage with Bubble Insertion

This block sits between the fetch register and the execute register of a five-stage pipeline. It takes the 32-bit instruction word presented by the fetch register, splits it into opcode, source indices, destination index and 16-bit immediate, and drives the two read indices of the register file. It then loads the decode/execute register with the operands, the extended immediate and a set of control and forwarding codes. The control decoder and the forwarding/hazard logic live outside, and their outputs arrive as inputs.

Operand A is normally the first register read. For shift instructions it is the 5-bit first-index field itself, which carries the shift amount. The second read index comes from the destination field for stores, because a store names its data register there, and from the low five bits otherwise. When a load-use hazard is flagged, or the instruction one stage ahead is a taken branch, the stage turns the instruction into a bubble. It does this by clearing only the three enables that change architectural state: zero-flag write, register write and memory write. Opcode 9 is exempt from the load-use squash. A taken branch ahead squashes it like any other opcode. The decode/execute register loads on every clock and resets to a bubble.

Top module: `decode_stage`

## Requirements
- R1: `rd_idx_a` equals instruction bits 20:16. One clock after an instruction is presented, `idex_rd` holds its bits 25:21. The opcode is taken from bits 31:26.
- R2: `rd_idx_b` equals instruction bits 25:21 while `ctl_st_sel` is 1, and bits 4:0 while it is 0.
- R3: One clock later, `idex_opa` holds bits 20:16 zero-extended if `ctl_shift` was 1, and `rd_data_a` otherwise.
- R4: One clock later, `idex_opb` holds the value `rd_data_b` had at the clock edge.
- R5: One clock later, `idex_imm` holds bits 15:0 sign-extended if `ctl_sext` was 1, and zero-extended otherwise.
- R6: One clock later, each of `idex_wz`, `idex_wreg` and `idex_wmem` equals its control input ANDed with (`lu_hazard` is 0 OR the opcode is 9) and with `exmem_btaken` being 0.
- R7: The load flag, ALU operation, both forwarding codes, store-bypass select, is-store flag and branch flag are copied one clock later unchanged, whether or not the instruction is squashed.
- R8: While `rst_n` is 0, every output register is 0, so all three enables read 0 (a bubble).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_instr | input | 32 | Instruction from the fetch register |
| ctl_st_sel | input | 1 | Store: second index from bits 25:21 |
| ctl_shift | input | 1 | Shift: operand A is the bits 20:16 field |
| ctl_sext | input | 1 | Sign-extend the immediate |
| ctl_wz | input | 1 | Zero-flag write enable from the decoder |
| ctl_wreg | input | 1 | Register write enable from the decoder |
| ctl_wmem | input | 1 | Memory write enable from the decoder |
| ctl_load | input | 1 | Instruction is a load |
| ctl_aluop | input | 4 | ALU operation code |
| ctl_isstore | input | 1 | Is-store flag |
| ctl_btaken | input | 1 | Branch-taken flag from the decoder |
| fwd_a | input | 2 | Operand A forwarding code |
| fwd_b | input | 2 | Operand B forwarding code |
| st_byp | input | 1 | Store-data bypass select |
| lu_hazard | input | 1 | Load-use hazard present |
| exmem_btaken | input | 1 | Taken branch in the next stage |
| rd_idx_a | output | 5 | Register file read index A |
| rd_idx_b | output | 5 | Register file read index B |
| rd_data_a | input | 32 | Register file read data A |
| rd_data_b | input | 32 | Register file read data B |
| idex_opa | output | 32 | Latched operand A |
| idex_opb | output | 32 | Latched operand B |
| idex_imm | output | 32 | Latched extended immediate |
| idex_rd | output | 5 | Latched destination index |
| idex_wz | output | 1 | Latched zero-flag write enable |
| idex_wreg | output | 1 | Latched register write enable |
| idex_wmem | output | 1 | Latched memory write enable |
| idex_load | output | 1 | Latched load flag |
| idex_aluop | output | 4 | Latched ALU operation |
| idex_fwd_a | output | 2 | Latched forwarding code A |
| idex_fwd_b | output | 2 | Latched forwarding code B |
| idex_st_byp | output | 1 | Latched store-bypass select |
| idex_isstore | output | 1 | Latched is-store flag |
| idex_btaken | output | 1 | Latched branch-taken flag |

## Verification
The assertions assume that every control and hazard input is a settled 0 or 1 at each rising edge. They also assume the register file answers the read indices within the same cycle, so `rd_data_a` and `rd_data_b` already match the indices when the edge arrives. The bench changes all inputs only on the falling edge. It models the register file as a combinational two-read array in which index 0 reads as zero, and it writes that array only on the falling edge. The random stimulus draws opcode 9 and the hazard and branch flags often enough that every combination of the squash condition occurs.

// File: rtl/decode_stage.sv
module decode_stage #(
  parameter int XLEN   = 32,
  parameter int AOP_W  = 4,
  parameter int FWD_W  = 2,
  parameter logic [5:0] EXEMPT_OPC = 6'd9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ifid_instr,
  input  logic             ctl_st_sel,
  input  logic             ctl_shift,
  input  logic             ctl_sext,
  input  logic             ctl_wz,
  input  logic             ctl_wreg,
  input  logic             ctl_wmem,
  input  logic             ctl_load,
  input  logic [AOP_W-1:0] ctl_aluop,
  input  logic             ctl_isstore,
  input  logic             ctl_btaken,
  input  logic [FWD_W-1:0] fwd_a,
  input  logic [FWD_W-1:0] fwd_b,
  input  logic             st_byp,
  input  logic             lu_hazard,
  input  logic             exmem_btaken,
  output logic [4:0]       rd_idx_a,
  output logic [4:0]       rd_idx_b,
  input  logic [XLEN-1:0]  rd_data_a,
  input  logic [XLEN-1:0]  rd_data_b,
  output logic [XLEN-1:0]  idex_opa,
  output logic [XLEN-1:0]  idex_opb,
  output logic [XLEN-1:0]  idex_imm,
  output logic [4:0]       idex_rd,
  output logic             idex_wz,
  output logic             idex_wreg,
  output logic             idex_wmem,
  output logic             idex_load,
  output logic [AOP_W-1:0] idex_aluop,
  output logic [FWD_W-1:0] idex_fwd_a,
  output logic [FWD_W-1:0] idex_fwd_b,
  output logic             idex_st_byp,
  output logic             idex_isstore,
  output logic             idex_btaken
);
  localparam int IMM_W = 16;
  localparam int IDX_W = 5;

  logic [5:0]       opc;
  logic [IDX_W-1:0] f_rs1, f_rd, f_lo;
  logic             keep;
  logic [XLEN-1:0]  opa_n, imm_n;

  assign opc   = ifid_instr[31:26];
  assign f_rd  = ifid_instr[25:21];
  assign f_rs1 = ifid_instr[20:16];
  assign f_lo  = ifid_instr[4:0];

  assign rd_idx_a = f_rs1;
  assign rd_idx_b = ctl_st_sel ? f_rd : f_lo;

  assign keep  = (!lu_hazard || opc == EXEMPT_OPC) && !exmem_btaken;
  assign opa_n = ctl_shift ? {{(XLEN-IDX_W){1'b0}}, f_rs1} : rd_data_a;
  assign imm_n = ctl_sext ? {{(XLEN-IMM_W){ifid_instr[IMM_W-1]}}, ifid_instr[IMM_W-1:0]}
                          : {{(XLEN-IMM_W){1'b0}}, ifid_instr[IMM_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_opa     <= '0;
      idex_opb     <= '0;
      idex_imm     <= '0;
      idex_rd      <= '0;
      idex_wz      <= 1'b0;
      idex_wreg    <= 1'b0;
      idex_wmem    <= 1'b0;
      idex_load    <= 1'b0;
      idex_aluop   <= '0;
      idex_fwd_a   <= '0;
      idex_fwd_b   <= '0;
      idex_st_byp  <= 1'b0;
      idex_isstore <= 1'b0;
      idex_btaken  <= 1'b0;
    end else begin
      idex_opa     <= opa_n;
      idex_opb     <= rd_data_b;
      idex_imm     <= imm_n;
      idex_rd      <= f_rd;
      idex_wz      <= ctl_wz   & keep;
      idex_wreg    <= ctl_wreg & keep;
      idex_wmem    <= ctl_wmem & keep;
      idex_load    <= ctl_load;
      idex_aluop   <= ctl_aluop;
      idex_fwd_a   <= fwd_a;
      idex_fwd_b   <= fwd_b;
      idex_st_byp  <= st_byp;
      idex_isstore <= ctl_isstore;
      idex_btaken  <= ctl_btaken;
    end
  end
endmodule

// File: rtl/decode_stage_chk.sv
module decode_stage_chk #(
  parameter int XLEN  = 32,
  parameter int AOP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ifid_instr,
  input logic             ctl_shift,
  input logic             ctl_sext,
  input logic [AOP_W-1:0] ctl_aluop,
  input logic             lu_hazard,
  input logic             exmem_btaken,
  input logic [XLEN-1:0]  idex_opa,
  input logic [XLEN-1:0]  idex_imm,
  input logic [4:0]       idex_rd,
  input logic             idex_wz,
  input logic             idex_wreg,
  input logic             idex_wmem,
  input logic [AOP_W-1:0] idex_aluop
);
  always @(posedge clk)
    if (!rst_n) assert_reset_bubble_R8: assert (!idex_wz && !idex_wreg && !idex_wmem);

  assert_dest_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> idex_rd == $past(ifid_instr[25:21]));

  assert_shift_amount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_shift |=> idex_opa == {{(XLEN-5){1'b0}}, $past(ifid_instr[20:16])});

  assert_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sext && ifid_instr[15]) |=> &idex_imm[XLEN-1:16]);

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_sext |=> idex_imm[XLEN-1:16] == '0);

  assert_branch_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_btaken |=> !idex_wz && !idex_wreg && !idex_wmem);

  assert_hazard_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_hazard && ifid_instr[31:26] != 6'd9) |=> !idex_wz && !idex_wreg && !idex_wmem);

  assert_aluop_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> idex_aluop == $past(ctl_aluop));
endmodule

bind decode_stage decode_stage_chk #(.XLEN(XLEN), .AOP_W(AOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .ctl_shift(ctl_shift),
  .ctl_sext(ctl_sext), .ctl_aluop(ctl_aluop), .lu_hazard(lu_hazard),
  .exmem_btaken(exmem_btaken), .idex_opa(idex_opa), .idex_imm(idex_imm),
  .idex_rd(idex_rd), .idex_wz(idex_wz), .idex_wreg(idex_wreg),
  .idex_wmem(idex_wmem), .idex_aluop(idex_aluop)
);

// File: tb/test_decode_stage.sv
`timescale 1ns/1ps
module test_decode_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ifid_instr = '0;
  logic ctl_st_sel = 0, ctl_shift = 0, ctl_sext = 0, ctl_wz = 0, ctl_wreg = 0, ctl_wmem = 0;
  logic ctl_load = 0, ctl_isstore = 0, ctl_btaken = 0, st_byp = 0, lu_hazard = 0, exmem_btaken = 0;
  logic [3:0] ctl_aluop = '0;
  logic [1:0] fwd_a = '0, fwd_b = '0;
  logic [4:0] rd_idx_a, rd_idx_b, idex_rd;
  logic [31:0] rd_data_a, rd_data_b, idex_opa, idex_opb, idex_imm;
  logic idex_wz, idex_wreg, idex_wmem, idex_load, idex_st_byp, idex_isstore, idex_btaken;
  logic [3:0] idex_aluop;
  logic [1:0] idex_fwd_a, idex_fwd_b;
  logic [31:0] rf [32];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign rd_data_a = (rd_idx_a == 5'd0) ? 32'd0 : rf[rd_idx_a];
  assign rd_data_b = (rd_idx_b == 5'd0) ? 32'd0 : rf[rd_idx_b];

  decode_stage i_decode_stage (
    .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .ctl_st_sel(ctl_st_sel),
    .ctl_shift(ctl_shift), .ctl_sext(ctl_sext), .ctl_wz(ctl_wz), .ctl_wreg(ctl_wreg),
    .ctl_wmem(ctl_wmem), .ctl_load(ctl_load), .ctl_aluop(ctl_aluop), .ctl_isstore(ctl_isstore),
    .ctl_btaken(ctl_btaken), .fwd_a(fwd_a), .fwd_b(fwd_b), .st_byp(st_byp),
    .lu_hazard(lu_hazard), .exmem_btaken(exmem_btaken), .rd_idx_a(rd_idx_a),
    .rd_idx_b(rd_idx_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .idex_opa(idex_opa), .idex_opb(idex_opb), .idex_imm(idex_imm), .idex_rd(idex_rd),
    .idex_wz(idex_wz), .idex_wreg(idex_wreg), .idex_wmem(idex_wmem), .idex_load(idex_load),
    .idex_aluop(idex_aluop), .idex_fwd_a(idex_fwd_a), .idex_fwd_b(idex_fwd_b),
    .idex_st_byp(idex_st_byp), .idex_isstore(idex_isstore), .idex_btaken(idex_btaken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rf_read(input logic [4:0] idx);
    return (idx == 5'd0) ? 32'd0 : rf[idx];
  endfunction

  function automatic logic [31:0] exp_imm(input logic [31:0] ins, input logic sx);
    return sx ? {{16{ins[15]}}, ins[15:0]} : {16'd0, ins[15:0]};
  endfunction

  function automatic logic exp_keep(input logic [31:0] ins, input logic hz, input logic bt);
    return (!hz || ins[31:26] == 6'd9) && !bt;
  endfunction

  // Inputs are already driven (at a falling edge); compute, clock, then compare.
  task automatic step;
    logic [4:0] ib;
    logic [31:0] e_opa, e_opb, e_imm;
    logic k;
    logic [10:0] side;
    #1;
    ib = ctl_st_sel ? ifid_instr[25:21] : ifid_instr[4:0];
    chk("R1 rd_idx_a", {27'd0, rd_idx_a}, {27'd0, ifid_instr[20:16]});
    chk("R2 rd_idx_b", {27'd0, rd_idx_b}, {27'd0, ib});
    e_opa = ctl_shift ? {27'd0, ifid_instr[20:16]} : rf_read(ifid_instr[20:16]);
    e_opb = rf_read(ib);
    e_imm = exp_imm(ifid_instr, ctl_sext);
    k = exp_keep(ifid_instr, lu_hazard, exmem_btaken);
    side = {ctl_load, ctl_aluop, fwd_a, fwd_b, st_byp, ctl_isstore} ;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idex_rd", {27'd0, idex_rd}, {27'd0, ifid_instr[25:21]});
    chk("R3 idex_opa", idex_opa, e_opa);
    chk("R4 idex_opb", idex_opb, e_opb);
    chk("R5 idex_imm", idex_imm, e_imm);
    chk("R6 enables", {29'd0, idex_wz, idex_wreg, idex_wmem},
        {29'd0, ctl_wz & k, ctl_wreg & k, ctl_wmem & k});
    chk("R7 side fields", {21'd0, idex_load, idex_aluop, idex_fwd_a, idex_fwd_b, idex_st_byp, idex_isstore},
        {21'd0, side});
    chk("R7 btaken", {31'd0, idex_btaken}, {31'd0, ctl_btaken});
  endtask

  task automatic drive_rand;
    logic [31:0] r;
    r = $urandom;
    ifid_instr = $urandom;
    if (r[2:0] == 3'd0) ifid_instr[31:26] = 6'd9;
    ctl_st_sel = r[3]; ctl_shift = r[4]; ctl_sext = r[5];
    ctl_wz = r[6]; ctl_wreg = r[7]; ctl_wmem = r[8]; ctl_load = r[9];
    ctl_aluop = r[13:10]; ctl_isstore = r[14]; ctl_btaken = r[15];
    fwd_a = r[17:16]; fwd_b = r[19:18]; st_byp = r[20];
    lu_hazard = r[21]; exmem_btaken = (r[24:22] == 3'd0);
  endtask

  task automatic set_ctl(input logic [31:0] ins, input logic hz, input logic bt);
    ifid_instr = ins; lu_hazard = hz; exmem_btaken = bt;
    ctl_wz = 1; ctl_wreg = 1; ctl_wmem = 1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf[i] = $urandom;
    drive_rand();
    ctl_wz = 1; ctl_wreg = 1; ctl_wmem = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset holds a bubble even with enables requested
    chk("R8 reset enables", {29'd0, idex_wz, idex_wreg, idex_wmem}, 32'd0);
    chk("R8 reset opa", idex_opa, 32'd0);
    chk("R8 reset aluop", {28'd0, idex_aluop}, 32'd0);
    rst_n = 1'b1;

    // R6: hazard, non-exempt opcode -> squashed; R7 side fields still pass
    set_ctl({6'd4, 5'd3, 5'd7, 16'h1234}, 1, 0); ctl_aluop = 4'hA; step();
    // R6: hazard, opcode 9 -> not squashed
    set_ctl({6'd9, 5'd3, 5'd7, 16'h8001}, 1, 0); ctl_st_sel = 1; step();
    // R6: opcode 9 with branch ahead -> squashed
    set_ctl({6'd9, 5'd3, 5'd7, 16'h8001}, 0, 1); step();
    // R2/R3: store indexing, shift amount, index 0 reads zero
    set_ctl({6'd2, 5'd0, 5'd31, 16'h0000}, 0, 0); ctl_st_sel = 1; ctl_shift = 1; step();
    ctl_shift = 0; ctl_st_sel = 0; ifid_instr = {6'd2, 5'd5, 5'd0, 16'hFFE0}; step();
    // R5: sign and zero extension of a negative immediate
    ifid_instr = {6'd1, 5'd1, 5'd2, 16'hFFFF}; ctl_sext = 1; step();
    ctl_sext = 0; step();

    for (int n = 0; n < 400; n++) begin
      if (n % 7 == 3) rf[$urandom % 32] = $urandom;
      drive_rand();
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule